// File: doc/BRIEF.md
# Associative Page Translator with First-In-First-Out Replacement

This block turns a virtual address into a physical address for a small paged system. The virtual address carries a page number in its upper bits and a line offset in its lower bits. The page table holds only as many entries as there are physical blocks. Each entry's position is its block number, and the entry holds the page that currently lives there. A lookup compares the page number against every valid entry at once. On a match the block number and the unchanged line form the physical address. When nothing matches, the block raises a page fault and reports the page that missed.

The surrounding system services the fault by moving the page in from backing store, then pulses a load-complete input. The block installs the pending page in the lowest-numbered free block if one exists. Otherwise it reuses the block of the page that has been resident longest, and reports that evicted page so it can be written out. A queue records blocks in the order they were loaded. Hits do not reorder it.

Top module: `pgx_translator`

## Requirements
- R1: After reset every entry is invalid: hit_o, fault_o and evict_valid_o are 0, and the first lookup of any page faults.
- R2: One cycle after a lookup (req_valid_i high at a rising edge) of a resident page, hit_o is 1, fault_o is 0 and paddr_o equals {block, line}. The block is paddr_o's upper BLK_W bits and the line is vaddr_i[LINE_W-1:0]. When hit_o is 0, paddr_o is 0.
- R3: One cycle after a lookup of a non-resident page, fault_o is 1, hit_o is 0 and fault_page_o equals vaddr_i[VA_W-1:LINE_W]. hit_o and fault_o are never high together.
- R4: A load-complete pulse while a fault is pending, with at least one free block, installs the pending page in the lowest-numbered free block. evict_valid_o stays 0.
- R5: A load-complete pulse while a fault is pending, with no free block, evicts the page loaded earliest. One cycle later evict_valid_o is 1 for one cycle with evict_page_o equal to that page. The new page takes the evicted page's block, and the evicted page faults afterwards.
- R6: A hit on a resident page does not change the order in which pages are later evicted.
- R7: A load-complete pulse with no fault pending changes no entry and does not raise evict_valid_o.
- R8: hit_o and fault_o are single-cycle results. Both are 0 in any cycle that does not follow a lookup.
- R9: If several faults occur before a load-complete pulse, the page of the most recent fault is the one installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Lookup request strobe |
| vaddr_i | input | PAGE_W+LINE_W | Virtual address: page number, then line |
| load_done_i | input | 1 | Pending page has arrived; install it |
| hit_o | output | 1 | Previous-cycle lookup hit |
| paddr_o | output | BLK_W+LINE_W | Physical address for the hit |
| fault_o | output | 1 | Previous-cycle lookup missed |
| fault_page_o | output | PAGE_W | Page number that missed |
| evict_valid_o | output | 1 | A page was evicted by the last install |
| evict_page_o | output | PAGE_W | Page number evicted |

## Verification
The hardest situation to bring about is an eviction where replacement order and access recency differ. A page is loaded first, then hit many times while others load, and it must still be the page evicted. Directed stimulus fills all four blocks, hammers the oldest page with hits, then forces a fault and an install. A long random run of lookups over all eight pages, with load-complete pulses issued only some of the time, covers the remaining cases. These include repeated faults before a load, back-to-back evictions and stray load pulses. The bench follows them with its own table-and-queue model.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
   typedef enum logic [1:0] {
      LD_NONE  = 2'd0,
      LD_FREE  = 2'd1,
      LD_EVICT = 2'd2
   } ld_kind_e;
endpackage

// File: rtl/pgx_cam.sv
module pgx_cam #(
   parameter int PAGE_W = 3,
   parameter int BLK_W  = 2,
   localparam int NUM   = 1 << BLK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PAGE_W-1:0] key_i,
   input  logic              wr_en_i,
   input  logic [BLK_W-1:0]  wr_blk_i,
   input  logic [PAGE_W-1:0] wr_page_i,
   input  logic [BLK_W-1:0]  rd_blk_i,
   output logic [PAGE_W-1:0] rd_page_o,
   output logic [NUM-1:0]    match_o,
   output logic [NUM-1:0]    valid_o
);
   logic [PAGE_W-1:0] page_q [NUM];
   logic [NUM-1:0]    valid_q;

   for (genvar gi = 0; gi < NUM; gi++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q[gi] <= 1'b0;
            page_q[gi]  <= '0;
         end else if (wr_en_i && wr_blk_i == BLK_W'(gi)) begin
            valid_q[gi] <= 1'b1;
            page_q[gi]  <= wr_page_i;
         end
      end
      assign match_o[gi] = valid_q[gi] && (page_q[gi] == key_i);
   end

   assign valid_o   = valid_q;
   assign rd_page_o = page_q[rd_blk_i];

   AST_CAM_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_o)); // R2
endmodule

// File: rtl/pgx_alloc.sv
module pgx_alloc #(
   parameter int BLK_W = 2,
   localparam int NUM  = 1 << BLK_W
) (
   input  logic [NUM-1:0]   valid_i,
   output logic             has_free_o,
   output logic [BLK_W-1:0] free_blk_o
);
   always_comb begin
      has_free_o = 1'b0;
      free_blk_o = '0;
      for (int i = NUM - 1; i >= 0; i--) begin
         if (!valid_i[i]) begin
            has_free_o = 1'b1;
            free_blk_o = i[BLK_W-1:0];
         end
      end
   end
endmodule

// File: rtl/pgx_fifo.sv
module pgx_fifo #(
   parameter int W     = 2,
   parameter int DEPTH = 4,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic         pop_i,
   input  logic [W-1:0] din_i,
   output logic [W-1:0] head_o,
   output logic [AW:0]  count_o
);
   logic [W-1:0]  mem_q [DEPTH];
   logic [AW-1:0] rd_q, wr_q;
   logic [AW:0]   cnt_q;

   initial begin : elab_chk
      assert ((1 << AW) == DEPTH) else $error("pgx_fifo: DEPTH must be a power of two");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_i) begin
            mem_q[wr_q] <= din_i;
            wr_q        <= wr_q + 1'b1;
         end
         if (pop_i) rd_q <= rd_q + 1'b1;
         if (push_i && !pop_i) cnt_q <= cnt_q + 1'b1;
         else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
      end
   end

   assign head_o  = mem_q[rd_q];
   assign count_o = cnt_q;

   AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i) |-> (cnt_q < (AW+1)'(DEPTH))); // R5
   AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> (cnt_q != '0)); // R5
endmodule

// File: rtl/pgx_translator.sv
module pgx_translator #(
   parameter int PAGE_W = 3,
   parameter int LINE_W = 10,
   parameter int BLK_W  = 2,
   localparam int VA_W  = PAGE_W + LINE_W,
   localparam int PA_W  = BLK_W + LINE_W,
   localparam int NUM   = 1 << BLK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   input  logic [VA_W-1:0]   vaddr_i,
   input  logic              load_done_i,
   output logic              hit_o,
   output logic [PA_W-1:0]   paddr_o,
   output logic              fault_o,
   output logic [PAGE_W-1:0] fault_page_o,
   output logic              evict_valid_o,
   output logic [PAGE_W-1:0] evict_page_o
);
   import pgx_pkg::*;

   initial begin : elab_chk
      assert (PAGE_W >= BLK_W) else $error("pgx_translator: fewer pages than blocks");
      assert (LINE_W >= 1)     else $error("pgx_translator: LINE_W must be positive");
   end

   logic [PAGE_W-1:0] page;
   logic [LINE_W-1:0] line;
   logic [NUM-1:0]    match_vec, valid_vec;
   logic              any_match, has_free, do_load;
   logic [BLK_W-1:0]  hit_blk, free_blk, head_blk, tgt_blk;
   logic [PAGE_W-1:0] head_page;
   logic [BLK_W:0]    fifo_cnt;
   ld_kind_e          ld_kind;
   logic              pend_q;
   logic [PAGE_W-1:0] pend_page_q;

   assign page = vaddr_i[VA_W-1:LINE_W];
   assign line = vaddr_i[LINE_W-1:0];

   pgx_cam #(.PAGE_W(PAGE_W), .BLK_W(BLK_W)) cam_i (
      .clk(clk), .rst_n(rst_n), .key_i(page),
      .wr_en_i(do_load), .wr_blk_i(tgt_blk), .wr_page_i(pend_page_q),
      .rd_blk_i(head_blk), .rd_page_o(head_page),
      .match_o(match_vec), .valid_o(valid_vec));

   pgx_alloc #(.BLK_W(BLK_W)) alloc_i (
      .valid_i(valid_vec), .has_free_o(has_free), .free_blk_o(free_blk));

   pgx_fifo #(.W(BLK_W), .DEPTH(NUM)) fifo_i (
      .clk(clk), .rst_n(rst_n),
      .push_i(do_load), .pop_i(do_load && ld_kind == LD_EVICT),
      .din_i(tgt_blk), .head_o(head_blk), .count_o(fifo_cnt));

   always_comb begin
      hit_blk = '0;
      for (int i = 0; i < NUM; i++)
         if (match_vec[i]) hit_blk = i[BLK_W-1:0];
   end
   assign any_match = |match_vec;

   assign do_load = load_done_i && pend_q;
   always_comb begin
      if (!do_load)      ld_kind = LD_NONE;
      else if (has_free) ld_kind = LD_FREE;
      else               ld_kind = LD_EVICT;
   end
   assign tgt_blk = has_free ? free_blk : head_blk;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_o         <= 1'b0;
         fault_o       <= 1'b0;
         paddr_o       <= '0;
         fault_page_o  <= '0;
         evict_valid_o <= 1'b0;
         evict_page_o  <= '0;
         pend_q        <= 1'b0;
         pend_page_q   <= '0;
      end else begin
         hit_o         <= req_valid_i && any_match;
         fault_o       <= req_valid_i && !any_match;
         paddr_o       <= (req_valid_i && any_match) ? {hit_blk, line} : '0;
         evict_valid_o <= (ld_kind == LD_EVICT);
         if (ld_kind == LD_EVICT) evict_page_o <= head_page;
         if (req_valid_i && !any_match) begin
            fault_page_o <= page;
            pend_q       <= 1'b1;
            pend_page_q  <= page;
         end else if (do_load) begin
            pend_q <= 1'b0;
         end
      end
   end

   AST_HIT_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_o && fault_o)); // R3
   AST_RESULT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_o || fault_o) |-> $past(req_valid_i)); // R8
   AST_EVICT_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      evict_valid_o |-> $past(load_done_i)); // R5
   AST_EVICT_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (do_load && !has_free) |-> (fifo_cnt == (BLK_W+1)'(NUM))); // R5
   AST_FREE_NO_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
      (do_load && has_free) |=> !evict_valid_o); // R4
   AST_IDLE_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (load_done_i && !pend_q) |=> !evict_valid_o); // R7
endmodule

// File: tb/pgx_translator_tb.sv
module pgx_translator_tb_top;
   localparam int PAGE_W = 3, LINE_W = 10, BLK_W = 2;
   localparam int NUM = 1 << BLK_W;

   logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0, load_done = 1'b0;
   logic [PAGE_W+LINE_W-1:0] vaddr = '0;
   logic hit, fault, evict_valid;
   logic [BLK_W+LINE_W-1:0] paddr;
   logic [PAGE_W-1:0] fault_page, evict_page;

   int checks = 0, errors = 0;
   int m_valid [NUM];
   int m_page  [NUM];
   int m_q     [NUM];
   int m_cnt = 0;
   int m_pend = 0, m_pend_page = 0;

   always #2 clk = ~clk;

   pgx_translator #(.PAGE_W(PAGE_W), .LINE_W(LINE_W), .BLK_W(BLK_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .vaddr_i(vaddr),
      .load_done_i(load_done), .hit_o(hit), .paddr_o(paddr), .fault_o(fault),
      .fault_page_o(fault_page), .evict_valid_o(evict_valid), .evict_page_o(evict_page));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int find_blk(input int pg);
      for (int i = 0; i < NUM; i++)
         if (m_valid[i] != 0 && m_page[i] == pg) return i;
      return -1;
   endfunction

   function automatic int free_blk();
      for (int i = 0; i < NUM; i++)
         if (m_valid[i] == 0) return i;
      return -1;
   endfunction

   task automatic lookup(input int pg, input int ln, input string req);
      int b;
      b = find_blk(pg);
      @(negedge clk);
      req_valid = 1'b1;
      vaddr = {pg[PAGE_W-1:0], ln[LINE_W-1:0]};
      @(negedge clk);
      req_valid = 1'b0;
      if (b >= 0) begin
         chk(hit === 1'b1 && fault === 1'b0, req, int'(hit), 1);
         chk(paddr === {b[BLK_W-1:0], ln[LINE_W-1:0]}, req, int'(paddr), (b << LINE_W) | ln);
      end else begin
         chk(fault === 1'b1 && hit === 1'b0, req, int'(fault), 1);
         chk(int'(fault_page) == pg, req, int'(fault_page), pg);
         chk(paddr === '0, req, int'(paddr), 0);
         m_pend = 1;
         m_pend_page = pg;
      end
   endtask

   task automatic load(input string req);
      int b, victim, vpage;
      victim = 0;
      vpage = 0;
      b = -1;
      if (m_pend != 0) begin
         b = free_blk();
         if (b < 0) begin
            victim = 1;
            b = m_q[0];
            vpage = m_page[b];
            for (int i = 0; i < NUM - 1; i++) m_q[i] = m_q[i+1];
            m_cnt--;
         end
         m_q[m_cnt] = b;
         m_cnt++;
         m_valid[b] = 1;
         m_page[b] = m_pend_page;
         m_pend = 0;
      end
      @(negedge clk);
      load_done = 1'b1;
      @(negedge clk);
      load_done = 1'b0;
      chk(evict_valid === 1'(victim), req, int'(evict_valid), victim);
      if (victim != 0) chk(int'(evict_page) == vpage, req, int'(evict_page), vpage);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : stim
      for (int i = 0; i < NUM; i++) begin
         m_valid[i] = 0;
         m_page[i] = 0;
         m_q[i] = 0;
      end
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(hit === 1'b0 && fault === 1'b0 && evict_valid === 1'b0, "R1 reset outputs",
          int'({hit, fault, evict_valid}), 0);
      lookup(5, 17, "R1 first lookup faults");
      // R4: fill four free blocks in order, no eviction
      load("R4 fill block0");
      lookup(2, 3, "R3 miss page2");   load("R4 fill block1");
      lookup(7, 0, "R3 miss page7");   load("R4 fill block2");
      lookup(0, 1023, "R3 miss page0"); load("R4 fill block3");
      lookup(5, 17, "R2 hit page5 block0");
      lookup(0, 1023, "R2 hit page0 block3");
      // R8: no lookup, no result
      @(negedge clk);
      chk(hit === 1'b0 && fault === 1'b0, "R8 idle cycle quiet", int'({hit, fault}), 0);
      // R6: hammer oldest page, it must still be evicted first
      for (int k = 0; k < 5; k++) lookup(5, k * 100, "R6 hit oldest page");
      lookup(3, 9, "R3 miss page3");
      load("R5 evict oldest page5");
      lookup(3, 9, "R5 new page in victim block0");
      lookup(5, 17, "R5 evicted page faults");
      // R9: a second fault replaces the pending page
      lookup(6, 4, "R9 second fault page6");
      load("R9 install latest, evict page2");
      lookup(6, 4, "R9 latest page resident");
      // R7: stray load pulse
      load("R7 stray load no evict");
      lookup(7, 55, "R7 table unchanged");
      // random mix
      for (int n = 0; n < 400; n++) begin
         int pg, ln, r;
         pg = int'($urandom % 8);
         ln = int'($urandom % 1024);
         r  = int'($urandom % 4);
         lookup(pg, ln, "R2 R3 random lookup");
         if (r == 0) load("R4 R5 R7 random load");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule